// File: doc/BRIEF.md
# Rotating-Token Shared-Bus Arbiter

This block arbitrates a shared bus among three requesters. Each requester drives a 3-bit operation code and a line address. A requester holds its operation steady until it is served, and the no-op code means "not requesting". The bus takes turns on every clock. In an arbitration cycle the block samples the requests and picks one winner. In the following grant cycle it drives the winner's operation and line address onto the bus and raises that requester's master flag.

A rotating priority token makes the choice fair. Whichever requester holds the token is searched first, then the next ones in index order, wrapping around. The token stays fixed across an arbitration cycle and moves on by one place after every grant cycle, so every requester comes first in turn. The data transfer, any timeout and the memory's reply are handled elsewhere.

No valid/ready handshake is used at either edge. A non-no-op code is the request valid, and the grant is the master flag. A requester sees back-pressure as its own flag staying low, and it keeps presenting the same operation until the flag rises.

Top module: `bus_token_arbiter`

## Requirements
- R1: The first cycle after reset is released is an arbitration cycle, with bus_op_o equal to the arbitrate marker code 5. From then on, bus_op_o alternates every cycle between 5 and a grant-cycle value that is never 5.
- R2: While rst_n is low, bus_op_o is no-op (code 0), master_o is 3 (none), master_flag_o is 0 and bus_line_o is 0.
- R3: When the token is k, requesters are examined in the order k, k+1, k+2 modulo 3. The first one whose code is a request wins. If no requester is requesting, the grant cycle shows master_o = 3.
- R4: In a grant cycle with a winner, bus_op_o, bus_line_o and master_o are the winner's operation, its line and its index. With no winner, bus_op_o is no-op (0). Operation codes: 0 no-op, 1 read, 2 exclusive read, 3 write, 4 invalidate.
- R5: master_o is 3 (none) in every arbitration cycle.
- R6: The token is 0 for the first arbitration after reset. It is unchanged through an arbitration cycle and advances by one modulo 3 after each grant cycle, whether or not that grant cycle had a winner.
- R7: master_flag_o bit i is 1 exactly when master_o equals i. All flag bits are 0 when master_o is 3.
- R8: bus_line_o keeps its previous value through every arbitration cycle and through any grant cycle without a winner.
- R9: Requester codes 5, 6 and 7 count as no request. They never win and never reach the bus.
- R10: Requests are sampled only at the end of an arbitration cycle. Changes made to them during the grant cycle do not alter that grant's outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_op_i | input | N*3 | Operation code per requester; requester i in bits [3i+2:3i] |
| req_line_i | input | N*LINE_W | Line address per requester; requester i in slice i |
| bus_op_o | output | 3 | Arbitrate marker (5) or granted operation |
| master_o | output | IDX_W | Granted requester index; N (3) means none |
| master_flag_o | output | N | One-hot master flags decoded from master_o |
| bus_line_o | output | LINE_W | Broadcast line address |

## Verification
On every cycle, the embedded assertions check the following:
- the phase alternation;
- that no master appears in an arbitration cycle;
- that a grant cycle without a winner carries no-op;
- that the line is held whenever there is no master;
- that the token is frozen in arbitration and steps by one after each grant.

Only the directed scenarios can show the following:
- which requester actually wins for a given token and request pattern;
- that the right operation and line are carried;
- that out-of-range codes are ignored;
- that a late change to the requests is not seen;
- that reset returns the priority to requester 0.

// File: rtl/bus_arb_pkg.sv
package bus_arb_pkg;
  localparam int OP_W = 3;

  typedef enum logic [OP_W-1:0] {
    OP_NOP   = 3'd0,
    OP_READ  = 3'd1,
    OP_XREAD = 3'd2,
    OP_WRITE = 3'd3,
    OP_INVAL = 3'd4,
    OP_ARB   = 3'd5
  } bus_op_e;

  function automatic logic op_is_req(input logic [OP_W-1:0] code);
    return (code == OP_READ) || (code == OP_XREAD) ||
           (code == OP_WRITE) || (code == OP_INVAL);
  endfunction
endpackage

// File: rtl/arb_token_ring.sv
module arb_token_ring #(
  parameter int N     = 3,
  parameter int TOK_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv_i,
  output logic [TOK_W-1:0] tok_o
);
  localparam logic [TOK_W-1:0] TOK_LAST = TOK_W'(N - 1);

  logic [TOK_W-1:0] tok_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     tok_q <= '0;
    else if (adv_i) tok_q <= (tok_q == TOK_LAST) ? '0 : tok_q + 1'b1;
  end

  assign tok_o = tok_q;

  AST_TOKEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !adv_i |=> $stable(tok_q)); // R6
  AST_TOKEN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    adv_i |=> (tok_q == (($past(tok_q) == TOK_LAST) ? '0 : $past(tok_q) + 1'b1))); // R6
endmodule

// File: rtl/arb_rr_pick.sv
module arb_rr_pick #(
  parameter int N     = 3,
  parameter int TOK_W = 2
) (
  input  logic [N-1:0]     req_vec_i,
  input  logic [TOK_W-1:0] tok_i,
  output logic             win_valid_o,
  output logic [TOK_W-1:0] win_idx_o
);
  always_comb begin
    win_valid_o = 1'b0;
    win_idx_o   = '0;
    for (int off = 0; off < N; off++) begin
      int idx;
      idx = (int'(tok_i) + off) % N;
      if (!win_valid_o && req_vec_i[idx]) begin
        win_valid_o = 1'b1;
        win_idx_o   = TOK_W'(idx);
      end
    end
  end
endmodule

// File: rtl/arb_flag_decode.sv
module arb_flag_decode #(
  parameter int N     = 3,
  parameter int IDX_W = 2
) (
  input  logic [IDX_W-1:0] idx_i,
  output logic [N-1:0]     flag_o
);
  for (genvar g = 0; g < N; g++) begin : g_flag
    assign flag_o[g] = (idx_i == IDX_W'(g));
  end
endmodule

// File: rtl/bus_token_arbiter.sv
module bus_token_arbiter
  import bus_arb_pkg::*;
#(
  parameter int N      = 3,
  parameter int LINE_W = 8,
  parameter int IDX_W  = $clog2(N + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [N*OP_W-1:0]     req_op_i,
  input  logic [N*LINE_W-1:0]   req_line_i,
  output logic [OP_W-1:0]       bus_op_o,
  output logic [IDX_W-1:0]      master_o,
  output logic [N-1:0]          master_flag_o,
  output logic [LINE_W-1:0]     bus_line_o
);
  localparam int TOK_W = (N > 1) ? $clog2(N) : 1;
  localparam logic [IDX_W-1:0] NONE = IDX_W'(N);

  logic [OP_W-1:0]   op_arr   [N];
  logic [LINE_W-1:0] line_arr [N];
  logic [N-1:0]      req_vec;

  for (genvar g = 0; g < N; g++) begin : g_req
    assign op_arr[g]   = req_op_i[g*OP_W +: OP_W];
    assign line_arr[g] = req_line_i[g*LINE_W +: LINE_W];
    assign req_vec[g]  = op_is_req(op_arr[g]);
  end

  logic [OP_W-1:0]   bus_op_q;
  logic [IDX_W-1:0]  master_q;
  logic [LINE_W-1:0] line_q;
  logic              boot_q;
  logic              arb_phase;
  logic              tok_adv;
  logic [TOK_W-1:0]  tok;
  logic              win_valid;
  logic [TOK_W-1:0]  win_idx;

  assign arb_phase = (bus_op_q == OP_ARB);
  assign tok_adv   = !arb_phase && !boot_q;

  arb_token_ring #(.N(N), .TOK_W(TOK_W)) u_tok (
    .clk   (clk),
    .rst_n (rst_n),
    .adv_i (tok_adv),
    .tok_o (tok)
  );

  arb_rr_pick #(.N(N), .TOK_W(TOK_W)) u_pick (
    .req_vec_i   (req_vec),
    .tok_i       (tok),
    .win_valid_o (win_valid),
    .win_idx_o   (win_idx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_op_q <= OP_NOP;
      master_q <= NONE;
      line_q   <= '0;
      boot_q   <= 1'b1;
    end else begin
      boot_q <= 1'b0;
      if (arb_phase) begin
        if (win_valid) begin
          bus_op_q <= op_arr[win_idx];
          master_q <= IDX_W'(win_idx);
          line_q   <= line_arr[win_idx];
        end else begin
          bus_op_q <= OP_NOP;
          master_q <= NONE;
        end
      end else begin
        bus_op_q <= OP_ARB;
        master_q <= NONE;
      end
    end
  end

  arb_flag_decode #(.N(N), .IDX_W(IDX_W)) u_flags (
    .idx_i  (master_q),
    .flag_o (master_flag_o)
  );

  assign bus_op_o   = bus_op_q;
  assign master_o   = master_q;
  assign bus_line_o = line_q;

  AST_PHASE_TO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    arb_phase |=> !arb_phase); // R1
  AST_PHASE_TO_ARB: assert property (@(posedge clk) disable iff (!rst_n)
    !arb_phase |=> arb_phase); // R1
  AST_ARB_NO_MASTER: assert property (@(posedge clk) disable iff (!rst_n)
    arb_phase |-> (master_q == NONE)); // R5
  AST_NOWIN_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    (!arb_phase && master_q == NONE) |-> (bus_op_q == OP_NOP)); // R4
  AST_IDLE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_phase && req_vec == '0) |=> (master_q == NONE && bus_op_q == OP_NOP)); // R9
  AST_LINE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (master_q == NONE) |-> $stable(line_q)); // R8
  AST_GRANT_IS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (master_q != NONE) |-> op_is_req(bus_op_q)); // R4
endmodule

// File: tb/sim_bus_token_arbiter.sv
`timescale 1ns/1ps
module sim_bus_token_arbiter;
  localparam int N = 3;
  localparam int LW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0]    rop [N];
  logic [LW-1:0] rln [N];
  logic [N*3-1:0]  req_op;
  logic [N*LW-1:0] req_line;
  logic [2:0]    bus_op;
  logic [1:0]    master;
  logic [N-1:0]  flags;
  logic [LW-1:0] bus_line;

  int errors = 0;
  int checks = 0;
  int tok = 0;
  logic [LW-1:0] exp_line = '0;
  bit finished = 0;

  always #2 clk = ~clk;

  for (genvar g = 0; g < N; g++) begin : g_pack
    assign req_op[g*3 +: 3]    = rop[g];
    assign req_line[g*LW +: LW] = rln[g];
  end

  bus_token_arbiter #(.N(N), .LINE_W(LW)) u0 (
    .clk(clk), .rst_n(rst_n), .req_op_i(req_op), .req_line_i(req_line),
    .bus_op_o(bus_op), .master_o(master), .master_flag_o(flags),
    .bus_line_o(bus_line)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic bit is_req(input logic [2:0] c);
    return c >= 3'd1 && c <= 3'd4;
  endfunction

  task automatic set_req(input logic [2:0] o0, o1, o2,
                         input logic [LW-1:0] l0, l1, l2);
    rop[0] = o0; rop[1] = o1; rop[2] = o2;
    rln[0] = l0; rln[1] = l1; rln[2] = l2;
  endtask

  // Called at a negedge inside an arbitration cycle.
  task automatic arb_round(input logic [2:0] o0, o1, o2,
                           input logic [LW-1:0] l0, l1, l2, input bit disturb);
    int win;
    logic [2:0] exp_op;
    win = 3;
    set_req(o0, o1, o2, l0, l1, l2);
    for (int off = 0; off < 3; off++) begin
      int i;
      i = (tok + off) % 3;
      if (win == 3 && is_req(rop[i])) win = i;
    end
    chk("R1", "arb marker", int'(bus_op), 5);
    chk("R5", "master in arb", int'(master), 3);
    exp_op = (win == 3) ? 3'd0 : rop[win];
    if (win != 3) exp_line = rln[win];
    @(posedge clk); #1;
    if (disturb) set_req(3'd1, 3'd1, 3'd1, 8'hEE, 8'hEE, 8'hEE);  // R10
    @(negedge clk);
    chk(disturb ? "R10" : "R4", "grant op", int'(bus_op), int'(exp_op));
    chk("R3", "master index", int'(master), win);
    chk("R7", "flags", int'(flags), (win == 3) ? 0 : (1 << win));
    chk(win == 3 ? "R8" : "R4", "grant line", int'(bus_line), int'(exp_line));
    tok = (tok + 1) % 3;
    @(negedge clk);
    chk("R1", "back to arb", int'(bus_op), 5);
    chk("R8", "line held in arb", int'(bus_line), int'(exp_line));
    chk("R7", "flags in arb", int'(flags), 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst_n = 1'b0;
    set_req(3'd0, 3'd0, 3'd0, 8'h00, 8'h00, 8'h00);
    @(negedge clk); @(negedge clk);
    chk("R2", "reset op", int'(bus_op), 0);
    chk("R2", "reset master", int'(master), 3);
    chk("R2", "reset flags", int'(flags), 0);
    chk("R2", "reset line", int'(bus_line), 0);
    rst_n = 1'b1;
    tok = 0;
    exp_line = '0;
    @(negedge clk);
    chk("R1", "first cycle is arb", int'(bus_op), 5);
  endtask

  task automatic t_single();  // R3 R6: lone requester wins regardless of token
    arb_round(3'd0, 3'd0, 3'd3, 8'h10, 8'h11, 8'h12, 0);
    arb_round(3'd2, 3'd0, 3'd0, 8'h20, 8'h21, 8'h22, 0);
    arb_round(3'd0, 3'd4, 3'd0, 8'h30, 8'h31, 8'h32, 0);
  endtask

  task automatic t_all();  // R3 R6: everyone requests, token order decides
    for (int r = 0; r < 4; r++)
      arb_round(3'd1, 3'd2, 3'd3, 8'h40, 8'h41, 8'h42, 0);
  endtask

  task automatic t_pair();  // R3: two requesters, search wraps
    arb_round(3'd4, 3'd0, 3'd1, 8'h50, 8'h51, 8'h52, 0);
    arb_round(3'd4, 3'd0, 3'd1, 8'h53, 8'h54, 8'h55, 0);
    arb_round(3'd4, 3'd0, 3'd1, 8'h56, 8'h57, 8'h58, 0);
  endtask

  task automatic t_idle();  // R4 R8: nobody requests
    arb_round(3'd0, 3'd0, 3'd0, 8'hA0, 8'hA1, 8'hA2, 0);
    arb_round(3'd0, 3'd0, 3'd0, 8'hB0, 8'hB1, 8'hB2, 0);
  endtask

  task automatic t_bad_codes();  // R9
    arb_round(3'd5, 3'd6, 3'd7, 8'hC0, 8'hC1, 8'hC2, 0);
    arb_round(3'd7, 3'd5, 3'd2, 8'hD0, 8'hD1, 8'hD2, 0);
    arb_round(3'd6, 3'd3, 3'd5, 8'hE0, 8'hE1, 8'hE2, 0);
  endtask

  task automatic t_late_change();  // R10
    arb_round(3'd0, 3'd3, 3'd0, 8'h61, 8'h62, 8'h63, 1);
    arb_round(3'd4, 3'd0, 3'd0, 8'h71, 8'h72, 8'h73, 1);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    set_req(3'd0, 3'd0, 3'd0, 8'h00, 8'h00, 8'h00);
    t_reset();
    t_single();
    t_all();
    t_pair();
    t_idle();
    t_bad_codes();
    t_late_change();
    t_reset();   // R6: token back to 0 after reset
    arb_round(3'd1, 3'd1, 3'd1, 8'h91, 8'h92, 8'h93, 0);
    t_all();
    finish_run();
  end

  initial begin
    #(200000 * 4);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end
endmodule